// File: doc/BRIEF.md
# Overload Fault Timer with Latch-Off

This block decides when a switching power controller must stop for good because of a sustained overload or a short circuit. On every switching cycle the current-limit comparator reports whether the peak current hit its ceiling. This block samples that flag once per cycle, at the cycle-start strobe. A single flagged period starts a tick-driven delay timer. If the timer runs its full length, an output latch is set and the controller's drive must stay off.

An intermittent fault must neither trip the latch early nor escape detection. For that reason one clean period does not stop the timer. It is cleared only after a configurable run of consecutive clean periods (three by default), and any flagged period restarts that run. Once the latch is set, nothing on the fault path can clear it. Only a brown-out reset or an undervoltage reset returns the block to idle.

The delay is a parameter counted in slow ticks. At a tick rate near 10 kHz, the default of 150 ticks gives about 15 ms.

Top module: `overload_fault_timer`

## Requirements
- R1: After the synchronous reset `rst`, `fault_latched` is 0.
- R2: `oc_flag` is sampled only in cycles where `cycle_strobe` is 1. A high flag in any other cycle has no effect.
- R3: A strobe with `oc_flag`=1 starts the timer from the next cycle. Every later cycle with `tick`=1 while the timer runs counts one tick. `fault_latched` rises in the cycle after the cycle that carries the `TIMER_TICKS`-th counted tick.
- R4: Fewer than `CLEAN_PERIODS` consecutive clean strobes (strobe with `oc_flag`=0) do not stop or clear the running timer.
- R5: The `CLEAN_PERIODS`-th consecutive clean strobe stops the timer and clears its count, so a later fault needs a full `TIMER_TICKS` window.
- R6: A strobe with `oc_flag`=1 resets the consecutive clean-period count to zero.
- R7: Once set, `fault_latched` stays 1 whatever happens on `oc_flag`, `cycle_strobe` and `tick`.
- R8: `bo_reset`=1 clears the latch, the timer and the clean count. `fault_latched` is 0 in the next cycle.
- R9: `uv_reset`=1 has the same clearing effect as `bo_reset`.
- R10: `tick` has no effect while the timer is not running.
- R11: If the expiring tick and the clearing clean strobe fall in the same cycle, the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag | input | 1 | Current-limit reached in this switching period |
| cycle_strobe | input | 1 | One-cycle pulse at the start of each switching period |
| tick | input | 1 | One-cycle pulse from the slow fault timebase |
| bo_reset | input | 1 | Brown-out reset event, clears everything |
| uv_reset | input | 1 | Supply fell to undervoltage-off, clears everything |
| fault_latched | output | 1 | Permanent fault; switching must stay disabled |

## Verification
The bench sweeps the number of clean periods inserted between faulted periods from zero to one past the clear threshold, and it uses two period lengths. A design that cleared the timer after one or two clean periods would latch late or never. A design that failed to restart the clean run on a new fault would clear a timer that should keep counting. The bench also checks the exact cycle in which the latch sets, so an off-by-one tick count shows up, and it checks that a high flag between strobes is ignored. It aligns the expiring tick with the clearing strobe to confirm that the latch wins. Finally, it drives every input after the latch sets, to show that only the two reset events release it.

// File: rtl/oft_pkg.sv
package oft_pkg;

    // Per-cycle decision produced by the period monitor
    typedef struct packed {
        logic fault_seen;   // flagged period began
        logic clean_done;   // required clean run completed
    } oft_period_evt_t;

    // Timer state
    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } oft_tmr_state_e;

    function automatic int unsigned oft_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/oft_period_mon.sv
module oft_period_mon
    import oft_pkg::*;
#(
    parameter int unsigned CLEAN_PERIODS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            cycle_strobe,
    input  logic            oc_flag,
    output oft_period_evt_t evt
);
    localparam int unsigned CCW = oft_width(CLEAN_PERIODS + 1);
    localparam logic [CCW-1:0] C_FULL = CCW'(CLEAN_PERIODS);
    localparam logic [CCW-1:0] C_LAST = CCW'(CLEAN_PERIODS - 1);

    logic [CCW-1:0] clean_cnt;

    always_comb begin
        evt.fault_seen = cycle_strobe && oc_flag;
        evt.clean_done = cycle_strobe && !oc_flag && (clean_cnt == C_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            clean_cnt <= '0;
        end else if (cycle_strobe) begin
            if (oc_flag)
                clean_cnt <= '0;
            else if (clean_cnt != C_FULL)
                clean_cnt <= clean_cnt + 1'b1;
        end
    end

    // R6: a flagged strobe restarts the clean run
    a_r6_fault_zeroes_run: assert property (@(posedge clk) disable iff (rst || clr)
        (cycle_strobe && oc_flag) |=> (clean_cnt == '0));

    a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
        clean_cnt <= C_FULL);

endmodule

// File: rtl/oft_tick_timer.sv
module oft_tick_timer
    import oft_pkg::*;
#(
    parameter int unsigned TIMER_TICKS = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic freeze,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic running,
    output logic expire
);
    localparam int unsigned TCW = oft_width(TIMER_TICKS);
    localparam logic [TCW-1:0] T_LAST = TCW'(TIMER_TICKS - 1);

    oft_tmr_state_e state;
    logic [TCW-1:0] count;

    assign running = (state == TMR_RUN);
    assign expire  = running && tick && !freeze && (count == T_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= TMR_IDLE;
            count <= '0;
        end else if (!freeze) begin
            if (expire) begin
                state <= TMR_IDLE;
                count <= '0;
            end else begin
                if (running && tick)
                    count <= count + 1'b1;
                if (start)
                    state <= TMR_RUN;
                else if (stop) begin
                    state <= TMR_IDLE;
                    count <= '0;
                end
            end
        end
    end

    // R10: an idle timer does not accumulate ticks
    a_r10_idle_no_count: assert property (@(posedge clk) disable iff (rst || clr)
        (!running && !start) |=> (count == '0));

    // R5: a stop without a fresh start leaves the count cleared
    a_r5_stop_clears: assert property (@(posedge clk) disable iff (rst || clr || freeze)
        (stop && !start && !expire) |=> (!running && count == '0));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
        count <= T_LAST);

endmodule

// File: rtl/oft_fault_latch.sv
module oft_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
    end

    // R7: the latch is released only by a clearing event
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);

endmodule

// File: rtl/overload_fault_timer.sv
module overload_fault_timer
    import oft_pkg::*;
#(
    parameter int unsigned TIMER_TICKS   = 150,
    parameter int unsigned CLEAN_PERIODS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_flag,
    input  logic cycle_strobe,
    input  logic tick,
    input  logic bo_reset,
    input  logic uv_reset,
    output logic fault_latched
);
    oft_period_evt_t evt;
    logic            clr;
    logic            tmr_running;
    logic            tmr_expire;

    assign clr = bo_reset || uv_reset;

    oft_period_mon #(.CLEAN_PERIODS(CLEAN_PERIODS)) u_mon (
        .clk          (clk),
        .rst          (rst),
        .clr          (clr),
        .cycle_strobe (cycle_strobe),
        .oc_flag      (oc_flag),
        .evt          (evt)
    );

    oft_tick_timer #(.TIMER_TICKS(TIMER_TICKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .freeze  (fault_latched),
        .start   (evt.fault_seen),
        .stop    (evt.clean_done),
        .tick    (tick),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    oft_fault_latch u_lat (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .set (tmr_expire),
        .q   (fault_latched)
    );

    // R8 / R9: either reset event releases the latch
    a_r8_bo_clears: assert property (@(posedge clk) disable iff (rst)
        bo_reset |=> !fault_latched);

    a_r9_uv_clears: assert property (@(posedge clk) disable iff (rst)
        uv_reset |=> !fault_latched);

    // R3: the latch only sets on a tick seen by a running timer
    a_r3_set_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched) |-> ($past(tick) && $past(tmr_running)));

endmodule

// File: tb/sim_overload_fault_timer.sv
module sim_overload_fault_timer;
    localparam int CLK_PERIOD = 10;
    localparam int TT = 12;   // timer length in ticks for the bench
    localparam int CP = 3;    // clean periods to clear

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oc = 1'b0, stb = 1'b0, tk = 1'b0, bo = 1'b0, uv = 1'b0;
    logic flt;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference state from the requirements
    bit m_run, m_lat;
    int m_cnt, m_clean;

    always #(CLK_PERIOD/2) clk = ~clk;

    overload_fault_timer #(.TIMER_TICKS(TT), .CLEAN_PERIODS(CP)) u0 (
        .clk(clk), .rst(rst), .oc_flag(oc), .cycle_strobe(stb), .tick(tk),
        .bo_reset(bo), .uv_reset(uv), .fault_latched(flt)
    );

    task automatic model_clear();
        m_run = 0; m_lat = 0; m_cnt = 0; m_clean = 0;
    endtask

    task automatic model_step(input bit s, f, t, b, u);
        bit exp_hit;
        if (b || u) begin
            model_clear();
        end else if (!m_lat) begin
            exp_hit = m_run && t && (m_cnt == TT - 1);
            if (exp_hit) begin
                m_lat = 1; m_run = 0; m_cnt = 0;     // R11: expiry wins
            end else begin
                if (m_run && t) m_cnt = m_cnt + 1;
                if (s && f) begin
                    m_run = 1; m_clean = 0;
                end else if (s) begin
                    if (m_clean == CP - 1) begin
                        m_run = 0; m_cnt = 0;
                    end
                    if (m_clean < CP) m_clean = m_clean + 1;
                end
            end
            if (exp_hit && s) begin
                if (f) m_clean = 0;
                else if (m_clean < CP) m_clean = m_clean + 1;
            end
        end
    endtask

    task automatic check(input string req, input logic act, input logic expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: fault_latched=%b expected %b at %0t", req, act, expv, $time);
        end
    endtask

    // one clock with the given inputs; compared against the model afterwards
    task automatic step(input bit s, f, t, b, u, input string req);
        stb = s; oc = f; tk = t; bo = b; uv = u;
        @(posedge clk);
        model_step(s, f, t, b, u);
        @(negedge clk);
        check(req, flt, m_lat);
    endtask

    // switching period: one strobe cycle, then n cycles each carrying a tick
    task automatic period(input bit f, input int n, input string req);
        step(1, f, 0, 0, 0, req);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, req);
    endtask

    task automatic bo_clear(input string req);
        step(0, 0, 0, 1, 0, req);
        step(0, 0, 0, 0, 0, req);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", flt, 1'b0);                       // R1 reset state

        // R10: ticks with no running timer
        for (int i = 0; i < 3 * TT; i++) step(0, 0, 1, 0, 0, "R10");
        check("R10", flt, 1'b0);

        // R2: flag high only between strobes, strobes see it low
        for (int p = 0; p < 10; p++) begin
            step(1, 0, 0, 0, 0, "R2");
            for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, "R2");
        end
        check("R2", flt, 1'b0);

        // R3: exact latch cycle
        bo_clear("R3");
        step(1, 1, 1, 0, 0, "R3");                    // tick here not counted
        for (int i = 0; i < TT - 1; i++) step(0, 0, 1, 0, 0, "R3");
        check("R3", flt, 1'b0);                       // TT-1 ticks counted
        step(0, 0, 1, 0, 0, "R3");
        check("R3", flt, 1'b1);                       // TT-th tick -> set

        // R7: latch holds through clean periods and faults
        for (int p = 0; p < 6; p++) period(p[0], 3, "R7");
        check("R7", flt, 1'b1);

        // R8: brown-out releases
        step(0, 0, 0, 1, 0, "R8");
        check("R8", flt, 1'b0);

        // sweep: k clean periods between faulted periods, two period lengths
        for (int pl = 2; pl <= 4; pl += 2) begin
            for (int k = 0; k <= CP + 1; k++) begin
                bo_clear(k < CP ? "R4" : "R5");
                for (int r = 0; r < 6; r++) begin
                    period(1, pl, k < CP ? "R4" : "R5");
                    for (int c = 0; c < k; c++) period(0, pl, k < CP ? "R4" : "R5");
                end
            end
        end

        // R4: two clean periods then a fault must not restart the window
        bo_clear("R4");
        period(1, 4, "R4");
        period(0, 4, "R4");
        period(0, 3, "R4");                           // 11 ticks so far
        check("R4", flt, 1'b0);
        step(0, 0, 1, 0, 0, "R4");
        check("R4", flt, 1'b1);

        // R6: fault resets the clean run, so 2+fault+2 never clears
        bo_clear("R6");
        period(1, 1, "R6");
        period(0, 1, "R6");
        period(0, 1, "R6");
        period(1, 1, "R6");
        period(0, 1, "R6");
        period(0, 1, "R6");
        for (int i = 0; i < TT; i++) step(0, 0, 1, 0, 0, "R6");
        check("R6", flt, 1'b1);

        // R5: three clean periods then a fresh full window
        bo_clear("R5");
        period(1, 5, "R5");
        period(0, 0, "R5");
        period(0, 0, "R5");
        period(0, 0, "R5");                           // cleared
        step(1, 1, 0, 0, 0, "R5");
        for (int i = 0; i < TT - 1; i++) step(0, 0, 1, 0, 0, "R5");
        check("R5", flt, 1'b0);
        step(0, 0, 1, 0, 0, "R5");
        check("R5", flt, 1'b1);

        // R9: undervoltage releases, also mid-count
        step(0, 0, 0, 0, 1, "R9");
        check("R9", flt, 1'b0);
        period(1, TT - 2, "R9");
        step(0, 0, 0, 0, 1, "R9");
        for (int i = 0; i < TT - 1; i++) step(0, 0, 1, 0, 0, "R9");
        check("R9", flt, 1'b0);

        // R11: expiring tick coincides with the clearing clean strobe
        bo_clear("R11");
        step(1, 1, 0, 0, 0, "R11");
        for (int i = 0; i < TT - 1; i++) step(0, 0, 1, 0, 0, "R11");
        step(1, 0, 0, 0, 0, "R11");
        step(1, 0, 0, 0, 0, "R11");
        step(1, 0, 1, 0, 0, "R11");
        check("R11", flt, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule